// File: doc/BRIEF.md
# Round-Robin Channel Scan Sequencer for a Multiplexed Converter

This block steps an eight-input multiplexed converter through a list of channels, one channel per step. Each step has three phases. The block first waits a conversion time. It then sends a four-bit channel address into the multiplexer over a serial select/clock/data link. Finally it asks an external frame reader to pull the 32-bit result out of the converter. That read also starts a new conversion on the channel just addressed.

The address for the next channel goes out before the result of the current one is read. So the word returned by each read belongs to the channel addressed one step earlier. The sequencer therefore labels each result with that earlier channel number. The first read after a start has no known source and is dropped.

The channels to visit are given by an enable mask. The sequencer takes them in ascending order and wraps around. If the mask is all zero, scanning stops. A rate input chooses between two wait lengths, each a parameter counted in system clock cycles.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `mux_cs`, `mux_sclk`, `mux_din`, `rd_start`, `res_valid` and `busy` are all low.
- R2: An address frame holds `mux_cs` high while exactly four bits are shifted. Each bit is sampled by the multiplexer on a rising edge of `mux_sclk`. The bit order is: enable (always 1), then channel bit 2, bit 1, bit 0. `mux_din` changes only while `mux_sclk` is low. `mux_sclk` is high only inside a frame.
- R3: After `start`, the first channel addressed is the lowest enabled channel. Each later step addresses the next enabled channel in ascending order, wrapping from 7 to 0. Channels whose mask bit is clear are skipped.
- R4: From the cycle `rd_done` is seen to the rise of `mux_cs` for the next frame, at least `WAIT_60` cycles pass when `rate_sel`=0, and at least `WAIT_50` cycles when `rate_sel`=1. The gap is never more than four cycles beyond that count.
- R5: `rd_start` is a one-cycle pulse. It is raised only after an address frame has ended, with `mux_cs` low. There is one pulse per step.
- R6: Each result is reported with `res_chan` equal to the channel addressed in the step before the read that produced it.
- R7: The read of the first step after `start` produces no `res_valid`. Every later read produces exactly one.
- R8: When the mask is all zero at the start of a step, `busy` falls and no further frames or reads occur. A `start` while the mask is zero is ignored.
- R9: `res_valid` is a one-cycle pulse, and `res_word` equals the `rd_word` presented with `rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins scanning |
| chan_mask | input | 8 | Channels to visit, one bit per channel |
| rate_sel | input | 1 | 0 selects the `WAIT_60` wait, 1 selects the `WAIT_50` wait |
| mux_cs | output | 1 | Multiplexer address select, high during a frame |
| mux_sclk | output | 1 | Address shift clock |
| mux_din | output | 1 | Address serial data |
| rd_start | output | 1 | Request to the frame reader |
| rd_done | input | 1 | Frame reader finished, `rd_word` valid |
| rd_word | input | 32 | Word read from the converter |
| res_valid | output | 1 | Tagged result strobe |
| res_word | output | 32 | Result word |
| res_chan | output | 3 | Channel the result belongs to |
| busy | output | 1 | Scanner active |

## Verification
The bench models the converter. Each read returns a word that carries the channel its conversion actually used, so a sequencer that labelled results with the channel just addressed, rather than the one before, would produce mismatched tags. A sparse mask, a single-bit mask and a full mask test the skip and wrap logic. A picker that did not wrap would stall or address a disabled channel. The wait gap is measured for both rate settings, which catches a rate input that is ignored or sampled at the wrong time. Halting and the first-frame discard are checked by comparing the number of reads with the number of results.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PICK,
    ST_ADDR,
    ST_READ
  } scan_state_t;
endpackage

// File: rtl/adc_scan_pick.sv
// Round-robin picker: the next enabled channel strictly after cur_ch, wrapping around.
module adc_scan_pick #(
  parameter int N_CH = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] mask,
  input  logic [CH_W-1:0] cur_ch,
  output logic [CH_W-1:0] nxt_ch,
  output logic            any_en
);
  always_comb begin
    int   k;
    logic found;
    nxt_ch = cur_ch;
    found  = 1'b0;
    for (int i = 1; i <= N_CH; i++) begin
      k = (int'(cur_ch) + i) % N_CH;
      if (!found && mask[k]) begin
        nxt_ch = CH_W'(k);
        found  = 1'b1;
      end
    end
    any_en = |mask;
  end
endmodule

// File: rtl/adc_scan_addr_tx.sv
// Serial address transmitter. The first bit goes out MSB first and is held
// through one high phase of sclk; the next bit is loaded on the falling edge.
module adc_scan_addr_tx #(
  parameter int NBITS    = 4,
  parameter int HALF_CYC = 2,
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1,
  localparam int BW = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NBITS-1:0] data,
  output logic             cs,
  output logic             sclk,
  output logic             sdo,
  output logic             done
);
  logic             active;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    nsent;
  logic [NBITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cs     <= 1'b0;
      sclk   <= 1'b0;
      sdo    <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      nsent  <= '0;
      sh     <= '0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        cs     <= 1'b1;
        sclk   <= 1'b0;
        sh     <= data;
        sdo    <= data[NBITS-1];
        cnt    <= '0;
        nsent  <= '0;
      end else if (active) begin
        if (cnt == CW'(HALF_CYC - 1)) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (nsent == BW'(NBITS - 1)) begin
              active <= 1'b0;
              cs     <= 1'b0;
              sdo    <= 1'b0;
              done   <= 1'b1;
            end else begin
              nsent <= nsent + 1'b1;
              sh    <= sh << 1;
              sdo   <= sh[NBITS-2];
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_timer.sv
// Down-counter: loads the limit, then reports expiry once it reaches zero.
module adc_scan_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= limit;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int WORD_W   = 32,
  parameter int HALF_CYC = 2,
  parameter int WAIT_60  = 6650000,
  parameter int WAIT_50  = 8000000,
  localparam int CH_W    = $clog2(N_CH),
  localparam int WMAX    = (WAIT_50 > WAIT_60) ? WAIT_50 : WAIT_60,
  localparam int TW      = $clog2(WMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_CH-1:0]   chan_mask,
  input  logic              rate_sel,
  output logic              mux_cs,
  output logic              mux_sclk,
  output logic              mux_din,
  output logic              rd_start,
  input  logic              rd_done,
  input  logic [WORD_W-1:0] rd_word,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic [CH_W-1:0]   res_chan,
  output logic              busy
);
  scan_state_t st, st_nxt;

  logic [CH_W-1:0] last_ch, tag_ch, pick_ch;
  logic            last_ok, tag_ok, any_en;
  logic            tmr_load, tmr_expired, tx_go, tx_done;
  logic [TW-1:0]   tmr_limit;

  adc_scan_pick #(.N_CH(N_CH)) u_pick (
    .mask   (chan_mask),
    .cur_ch (last_ch),
    .nxt_ch (pick_ch),
    .any_en (any_en)
  );

  assign tmr_limit = rate_sel ? TW'(WAIT_50) : TW'(WAIT_60);

  adc_scan_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .limit   (tmr_limit),
    .expired (tmr_expired)
  );

  adc_scan_addr_tx #(.NBITS(CH_W + 1), .HALF_CYC(HALF_CYC)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .go   (tx_go),
    .data ({1'b1, pick_ch}),
    .cs   (mux_cs),
    .sclk (mux_sclk),
    .sdo  (mux_din),
    .done (tx_done)
  );

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tx_go    = 1'b0;
    unique case (st)
      ST_IDLE: if (start && any_en) begin
        st_nxt   = ST_WAIT;
        tmr_load = 1'b1;
      end
      ST_WAIT: if (tmr_expired) st_nxt = ST_PICK;
      ST_PICK: begin
        if (!any_en) begin
          st_nxt = ST_IDLE;
        end else begin
          tx_go  = 1'b1;
          st_nxt = ST_ADDR;
        end
      end
      ST_ADDR: if (tx_done) st_nxt = ST_READ;
      ST_READ: if (rd_done) begin
        st_nxt   = ST_WAIT;
        tmr_load = 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      rd_start  <= 1'b0;
      res_valid <= 1'b0;
      res_word  <= '0;
      res_chan  <= '0;
      last_ch   <= CH_W'(N_CH - 1);
      last_ok   <= 1'b0;
      tag_ch    <= '0;
      tag_ok    <= 1'b0;
    end else begin
      st        <= st_nxt;
      busy      <= (st_nxt != ST_IDLE);
      rd_start  <= (st == ST_ADDR) && tx_done;
      res_valid <= 1'b0;
      if (st == ST_IDLE && start && any_en) begin
        last_ch <= CH_W'(N_CH - 1);
        last_ok <= 1'b0;
      end
      if (st == ST_PICK && any_en) begin
        tag_ch  <= last_ch;
        tag_ok  <= last_ok;
        last_ch <= pick_ch;
        last_ok <= 1'b1;
      end
      if (st == ST_READ && rd_done) begin
        res_valid <= tag_ok;
        if (tag_ok) begin
          res_word <= rd_word;
          res_chan <= tag_ch;
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic clk,
  input logic rst,
  input logic mux_cs,
  input logic mux_sclk,
  input logic mux_din,
  input logic rd_start,
  input logic res_valid,
  input logic busy
);
  a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    mux_sclk |-> mux_cs);

  a_r2_din_held_high: assert property (@(posedge clk) disable iff (rst)
    (mux_sclk && $past(mux_sclk)) |-> $stable(mux_din));

  a_r5_read_after_frame: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> !mux_cs);

  a_r5_start_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start);

  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mux_cs && !rd_start));
endmodule

bind adc_scan_seq adc_scan_seq_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .mux_cs    (mux_cs),
  .mux_sclk  (mux_sclk),
  .mux_din   (mux_din),
  .rd_start  (rd_start),
  .res_valid (res_valid),
  .busy      (busy)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int W60 = 40;
  localparam int W50 = 70;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  chan_mask = '0;
  logic        rate_sel = 1'b0;
  logic        rd_done = 1'b0;
  logic [31:0] rd_word = '0;
  wire         mux_cs, mux_sclk, mux_din, rd_start, res_valid, busy;
  wire  [31:0] res_word;
  wire  [2:0]  res_chan;

  always #10 clk = ~clk;

  adc_scan_seq #(.HALF_CYC(2), .WAIT_60(W60), .WAIT_50(W50)) i_adc_scan_seq (
    .clk(clk), .rst(rst), .start(start), .chan_mask(chan_mask), .rate_sel(rate_sel),
    .mux_cs(mux_cs), .mux_sclk(mux_sclk), .mux_din(mux_din),
    .rd_start(rd_start), .rd_done(rd_done), .rd_word(rd_word),
    .res_valid(res_valid), .res_word(res_word), .res_chan(res_chan), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor and converter model, all sampled on the falling edge.
  int          cyc = 0, done_cyc = 0, gap_min, gap_max;
  int          n_frames = 0, n_reads = 0, n_res = 0, dly = 0, nb = 0;
  logic        cs_q = 1'b0, sclk_q = 1'b0;
  logic [3:0]  bits = '0;
  logic [2:0]  addr_ch = '0, conv_ch = '0;
  logic        addr_known = 1'b0, conv_known = 1'b0;
  logic [23:0] seq = '0;
  logic [31:0] last_word = '0;
  logic [2:0]  flog [16];

  always @(negedge clk) begin
    cyc++;
    if (mux_cs && !cs_q) begin
      bits = '0; nb = 0;
      if (n_frames > 0) begin
        if (cyc - done_cyc < gap_min) gap_min = cyc - done_cyc;
        if (cyc - done_cyc > gap_max) gap_max = cyc - done_cyc;
      end
    end
    if (mux_sclk && !sclk_q) begin
      bits = {bits[2:0], mux_din};
      nb++;
    end
    if (!mux_cs && cs_q) begin
      chk(nb == 4, "R2 bit count", nb, 4);
      chk(bits[3] == 1'b1, "R2 enable bit first", bits[3], 1);
      addr_ch = bits[2:0];
      addr_known = 1'b1;
      if (n_frames < 16) flog[n_frames] = bits[2:0];
      n_frames++;
    end
    cs_q = mux_cs; sclk_q = mux_sclk;
    if (rd_done) rd_done = 1'b0;
    if (rd_start) begin
      chk(!mux_cs, "R5 read while addressing", mux_cs, 0);
      dly = 3;
    end else if (dly > 0) begin
      dly--;
      if (dly == 0) begin
        seq++;
        rd_word = {4'hA, conv_known, conv_ch, seq};
        last_word = rd_word;
        rd_done = 1'b1;
        done_cyc = cyc;
        n_reads++;
        conv_ch = addr_ch;
        conv_known = addr_known;
      end
    end
    if (res_valid) begin
      n_res++;
      chk(res_word == last_word, "R9 result word", res_word, last_word);
      chk(res_word[27] == 1'b1, "R7 result from unknown conversion", res_word[27], 1);
      chk(res_chan == res_word[26:24], "R6 channel tag", res_chan, res_word[26:24]);
    end
  end

  function automatic logic [2:0] next_en(input logic [7:0] m, input logic [2:0] cur);
    for (int i = 1; i <= 8; i++)
      if (m[(cur + i) % 8]) return 3'((cur + i) % 8);
    return cur;
  endfunction

  task automatic test_reset();
    chk(!mux_cs && !mux_sclk && !mux_din, "R1 mux lines after reset", {mux_cs, mux_sclk, mux_din}, 0);
    chk(!rd_start && !res_valid && !busy, "R1 control after reset", {rd_start, res_valid, busy}, 0);
  endtask

  task automatic test_scan(input logic [7:0] m, input logic rs, input int nf);
    logic [2:0] e;
    int lim;
    lim = rs ? W50 : W60;
    @(negedge clk);
    chan_mask = m; rate_sel = rs;
    conv_known = 1'b0; addr_known = 1'b0;
    n_frames = 0; n_reads = 0; n_res = 0;
    gap_min = 1 << 30; gap_max = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (n_frames >= nf);
    e = 3'd7;
    for (int i = 0; i < nf; i++) begin
      e = next_en(m, e);
      chk(flog[i] == e, "R3 scan order", flog[i], e);
    end
    chk(gap_min >= lim, "R4 wait minimum", gap_min, lim);
    chk(gap_max <= lim + 4, "R4 wait maximum", gap_max, lim + 4);
    // Halt by clearing the mask.
    @(negedge clk);
    chan_mask = '0;
    wait (!busy);
    repeat (20) @(negedge clk);
    chk(n_res == n_reads - 1, "R7 results vs reads", n_res, n_reads - 1);
    begin
      int f0;
      f0 = n_frames;
      repeat (200) @(negedge clk);
      chk(n_frames == f0 && !busy, "R8 halted stays quiet", n_frames, f0);
    end
  endtask

  task automatic test_zero_start();
    int f0;
    f0 = n_frames;
    @(negedge clk);
    chan_mask = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    chk(!busy && n_frames == f0, "R8 start ignored with empty mask", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_scan(8'hA5, 1'b0, 10);
    test_scan(8'h10, 1'b1, 4);
    test_scan(8'hFF, 1'b0, 12);
    test_scan(8'h81, 1'b1, 6);
    test_zero_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule